// File: doc/BRIEF.md
# Multichannel Slot Enable and Mask Selector

This block tracks the word slots of a time-division serial frame. For each slot it reports which channel number the slot carries. It also reports whether that channel is enabled for transmission and whether its data is masked. A frame-sync pulse restarts the slot count, and a slot-advance strobe steps it one slot at a time. The serial shifter that consumes these flags is outside the block, as are clock generation, FIFOs and the register bus.

Channels are grouped into blocks of `BLK_CH` channels. In the default 32-channel operation, two blocks are active. Partition A holds an even-numbered block and partition B holds an odd-numbered block. The frame starts with partition A and then alternates between B and A every `BLK_CH` slots until `NARROW_SLOTS` slots have gone by. In 128-channel operation, slot n simply is channel n, and the frame ends after `BLK_CH*NUM_BLK` slots.

A 2-bit selection mode picks how enables and masks are formed: all channels on, enabled by the transmit vector, masked by the transmit vector, or enable borrowed from the receive vector with a mask taken from the transmit vector. A disabled slot consumes no transmit word. A masked slot consumes a word but leaves the output undriven. The block has no data stream, so all of its pins are plain level or strobe signals with no back-pressure.

Top module: `tdm_slot_select`

## Requirements
- R1: In 32-channel operation (`wide_sel`=0), a slot in partition A carries channel `(2*blk_a)*16 + offset`, where offset is the slot number modulo 16. Partition A therefore only ever uses even blocks.
- R2: After frame sync, the first 16 slots belong to partition A. The partition then toggles every 16 slots. A slot in partition B carries channel `(2*blk_b+1)*16 + offset`.
- R3: Mode 2'b00 gives every active slot `ch_en`=1 and `ch_mask`=0, whatever the vectors hold.
- R4: Mode 2'b01 gives `ch_en` = the channel's transmit bit and `ch_mask`=0.
- R5: Mode 2'b10 gives `ch_en`=1 and `ch_mask` = NOT the channel's transmit bit.
- R6: Mode 2'b11 gives `ch_en` = the channel's receive bit and `ch_mask` = receive bit AND NOT transmit bit.
- R7: With `wide_sel`=1, slot n carries channel n, and its bits are `rx_en[n]` and `tx_en[n]`. The frame holds 128 slots.
- R8: A frame-sync pulse moves the block to slot 0 with `active`=1 on the next clock, and it takes priority over `slot_adv`. Each `slot_adv` while active adds one to the slot. A strobe on the last slot clears `active`, which then stays 0 until the next frame sync. While inactive, all of `ch_idx`, `ch_en`, `ch_mask` and `drive_en` are 0.
- R9: `drive_en` is 1 exactly when the slot is active, enabled and not masked.
- R10: During and right after reset, `active`, `ch_en`, `ch_mask`, `drive_en` and `ch_idx` are all 0.
- R11: In 32-channel operation, partition A reads bits [15:0] of each vector and partition B reads bits [31:16]. Bits [127:32] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame start pulse, restarts at slot 0 |
| slot_adv | input | 1 | Advance to next slot |
| sel_mode | input | 2 | Enable/mask selection mode |
| wide_sel | input | 1 | 1: 128-channel operation, 0: 32-channel two-partition operation |
| blk_a | input | 2 | Partition A block select (block = 2*blk_a) |
| blk_b | input | 2 | Partition B block select (block = 2*blk_b+1) |
| rx_en | input | 128 | Receive channel-enable vector |
| tx_en | input | 128 | Transmit channel-enable vector |
| active | output | 1 | A slot of the frame is current |
| ch_idx | output | 7 | Channel carried by the current slot |
| ch_en | output | 1 | Current channel enabled for transmit |
| ch_mask | output | 1 | Current channel masked |
| drive_en | output | 1 | Data output should be driven |

## Verification
The bench builds the block with its defaults: 16-channel blocks, eight blocks and a 64-slot narrow frame. Because the narrow frame is 64 slots long, the partition returns to A for a second round, so the A-B-A-B alternation is observed and not only a single switch. A 128-slot wide frame, including its end and the idle period that follows, fits in well under two hundred cycles. Each of the four modes is run with random vectors, irregular advance strobes and a frame sync that arrives mid-frame. Junk placed in vector bits [127:32] shows that narrow operation ignores them.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  typedef enum logic [1:0] {
    SEL_OFF       = 2'b00,
    SEL_TX_ENABLE = 2'b01,
    SEL_TX_MASK   = 2'b10,
    SEL_RX_BORROW = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int SLOT_W       = 7,
  parameter int NARROW_SLOTS = 64,
  parameter int WIDE_SLOTS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              slot_adv,
  input  logic              wide_sel,
  output logic              active,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST_N = SLOT_W'(NARROW_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LAST_W = SLOT_W'(WIDE_SLOTS - 1);

  logic [SLOT_W-1:0] last_slot;
  assign last_slot = wide_sel ? LAST_W : LAST_N;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (frame_sync) begin
      active <= 1'b1;
      slot   <= '0;
    end else if (slot_adv && active) begin
      if (slot >= last_slot) begin
        active <= 1'b0;
        slot   <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (active && slot == '0)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_adv && !frame_sync && slot < last_slot) |=> (active && slot == $past(slot) + 1'b1)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !frame_sync) |=> !active); // R8
endmodule

// File: rtl/tdm_chan_map.sv
module tdm_chan_map #(
  parameter int BLK_CH  = 16,
  parameter int NUM_BLK = 8,
  parameter int SLOT_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic [SLOT_W-1:0]          slot,
  input  logic                       wide_sel,
  input  logic [$clog2(NUM_BLK)-2:0] blk_a,
  input  logic [$clog2(NUM_BLK)-2:0] blk_b,
  input  logic [BLK_CH*NUM_BLK-1:0]  rx_en,
  input  logic [BLK_CH*NUM_BLK-1:0]  tx_en,
  output logic [SLOT_W-1:0]          ch_idx,
  output logic                       rx_bit,
  output logic                       tx_bit
);
  localparam int OFS_W = $clog2(BLK_CH);
  localparam int BLK_W = $clog2(NUM_BLK);
  localparam int NB_W  = OFS_W + 1;

  logic              part_b;
  logic [OFS_W-1:0]  ofs;
  logic [BLK_W-1:0]  blk;
  logic [NB_W-1:0]   narrow_bit;
  logic [SLOT_W-1:0] narrow_idx;

  assign part_b     = slot[OFS_W];
  assign ofs        = slot[OFS_W-1:0];
  assign blk        = part_b ? {blk_b, 1'b1} : {blk_a, 1'b0};
  assign narrow_idx = SLOT_W'({blk, ofs});
  assign narrow_bit = {part_b, ofs};

  always_comb begin
    if (wide_sel) begin
      ch_idx = slot;
      rx_bit = rx_en[slot];
      tx_bit = tx_en[slot];
    end else begin
      ch_idx = narrow_idx;
      rx_bit = rx_en[narrow_bit];
      tx_bit = tx_en[narrow_bit];
    end
  end

  AST_PART_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wide_sel) |-> (ch_idx[OFS_W] == slot[OFS_W])); // R2
endmodule

// File: rtl/tdm_mode_decode.sv
module tdm_mode_decode
  import tdm_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  sel_mode_e mode,
  input  logic      rx_bit,
  input  logic      tx_bit,
  output logic      ch_en,
  output logic      ch_mask,
  output logic      drive_en
);
  logic en_raw, mask_raw;

  always_comb begin
    unique case (mode)
      SEL_OFF:       begin en_raw = 1'b1;   mask_raw = 1'b0;              end
      SEL_TX_ENABLE: begin en_raw = tx_bit; mask_raw = 1'b0;              end
      SEL_TX_MASK:   begin en_raw = 1'b1;   mask_raw = !tx_bit;           end
      SEL_RX_BORROW: begin en_raw = rx_bit; mask_raw = rx_bit && !tx_bit; end
      default:       begin en_raw = 1'b0;   mask_raw = 1'b0;              end
    endcase
  end

  assign ch_en    = active && en_raw;
  assign ch_mask  = active && mask_raw;
  assign drive_en = ch_en && !ch_mask;

  AST_OFF_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == SEL_OFF) |-> (ch_en && !ch_mask)); // R3
  AST_TXEN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == SEL_TX_ENABLE) |-> !ch_mask); // R4
  AST_TXMASK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == SEL_TX_MASK) |-> ch_en); // R5
  AST_MASK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ch_mask |-> ch_en); // R6
endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
  import tdm_slot_pkg::*;
#(
  parameter int BLK_CH       = 16,
  parameter int NUM_BLK      = 8,
  parameter int NARROW_SLOTS = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frame_sync,
  input  logic                               slot_adv,
  input  logic [1:0]                         sel_mode,
  input  logic                               wide_sel,
  input  logic [$clog2(NUM_BLK)-2:0]         blk_a,
  input  logic [$clog2(NUM_BLK)-2:0]         blk_b,
  input  logic [BLK_CH*NUM_BLK-1:0]          rx_en,
  input  logic [BLK_CH*NUM_BLK-1:0]          tx_en,
  output logic                               active,
  output logic [$clog2(BLK_CH*NUM_BLK)-1:0]  ch_idx,
  output logic                               ch_en,
  output logic                               ch_mask,
  output logic                               drive_en
);
  localparam int WIDE_CH = BLK_CH * NUM_BLK;
  localparam int SLOT_W  = $clog2(WIDE_CH);

  logic [SLOT_W-1:0] slot, map_idx;
  logic              rx_bit, tx_bit;

  tdm_slot_counter #(.SLOT_W(SLOT_W), .NARROW_SLOTS(NARROW_SLOTS), .WIDE_SLOTS(WIDE_CH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_adv(slot_adv),
    .wide_sel(wide_sel), .active(active), .slot(slot)
  );

  tdm_chan_map #(.BLK_CH(BLK_CH), .NUM_BLK(NUM_BLK), .SLOT_W(SLOT_W)) u_map (
    .clk(clk), .rst_n(rst_n), .active(active), .slot(slot), .wide_sel(wide_sel),
    .blk_a(blk_a), .blk_b(blk_b), .rx_en(rx_en), .tx_en(tx_en),
    .ch_idx(map_idx), .rx_bit(rx_bit), .tx_bit(tx_bit)
  );

  tdm_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .active(active), .mode(sel_mode_e'(sel_mode)),
    .rx_bit(rx_bit), .tx_bit(tx_bit),
    .ch_en(ch_en), .ch_mask(ch_mask), .drive_en(drive_en)
  );

  assign ch_idx = active ? map_idx : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!drive_en && !ch_en && !ch_mask && ch_idx == '0)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !active); // R10
endmodule

// File: tb/tdm_slot_select_bench.sv
module tdm_slot_select_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0, slot_adv = 1'b0, wide_sel = 1'b0;
  logic [1:0] sel_mode = 2'b00, blk_a = 2'd0, blk_b = 2'd0;
  logic [127:0] rx_en = '0, tx_en = '0;
  logic active, ch_en, ch_mask, drive_en;
  logic [6:0] ch_idx;

  int total = 0, bad = 0;
  bit done = 0;
  bit r11_phase = 0;

  // behavioural reference state
  bit m_act = 0;
  int m_slot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_select u_tdm_slot_select (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_adv(slot_adv),
    .sel_mode(sel_mode), .wide_sel(wide_sel), .blk_a(blk_a), .blk_b(blk_b),
    .rx_en(rx_en), .tx_en(tx_en), .active(active), .ch_idx(ch_idx),
    .ch_en(ch_en), .ch_mask(ch_mask), .drive_en(drive_en)
  );

  always @(posedge clk) begin
    int last;
    last = wide_sel ? 127 : 63;
    if (!rst_n) begin
      m_act = 0; m_slot = 0;
    end else if (frame_sync) begin
      m_act = 1; m_slot = 0;
    end else if (slot_adv && m_act) begin
      if (m_slot >= last) begin m_act = 0; m_slot = 0; end
      else m_slot = m_slot + 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", tag, m_slot, act, exp);
    end
  endtask

  task automatic compare();
    int e_idx, bitn, e_en, e_mask;
    bit rb, tb;
    string idx_tag, md_tag;
    if (!m_act) begin
      e_idx = 0; e_en = 0; e_mask = 0;
      idx_tag = "R8"; md_tag = "R8";
    end else begin
      if (wide_sel) begin
        e_idx = m_slot; bitn = m_slot; idx_tag = "R7";
      end else begin
        int part = (m_slot / 16) % 2;
        e_idx = (part == 1 ? 2*blk_b + 1 : 2*blk_a) * 16 + m_slot % 16;
        bitn = part * 16 + m_slot % 16;
        idx_tag = (m_slot < 16) ? "R1" : "R2";
      end
      rb = rx_en[bitn]; tb = tx_en[bitn];
      case (sel_mode)
        2'b00: begin e_en = 1;  e_mask = 0;          md_tag = "R3"; end
        2'b01: begin e_en = tb; e_mask = 0;          md_tag = "R4"; end
        2'b10: begin e_en = 1;  e_mask = !tb;        md_tag = "R5"; end
        default: begin e_en = rb; e_mask = rb && !tb; md_tag = "R6"; end
      endcase
      if (r11_phase) md_tag = "R11";
    end
    check("R8 active", active, m_act);
    check({idx_tag, " ch_idx"}, ch_idx, e_idx);
    check({md_tag, " ch_en"}, ch_en, e_en);
    check({md_tag, " ch_mask"}, ch_mask, e_mask);
    check("R9 drive_en", drive_en, (e_en && !e_mask) ? 1 : 0);
  endtask

  task automatic cyc(bit fs, bit adv);
    @(negedge clk);
    frame_sync = fs; slot_adv = adv;
    #1 compare();
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R10 active", active, 0);
      check("R10 drive_en", drive_en, 0);
      check("R10 ch_idx", ch_idx, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 1);
    check("R10 idle after reset", active, 0);

    // narrow operation, each mode, irregular strobes
    for (int md = 0; md < 4; md++) begin
      sel_mode = 2'(md); wide_sel = 0;
      blk_a = 2'(md); blk_b = 2'(3 - md);
      rx_en = rnd128(); tx_en = rnd128();
      cyc(1, 1);  // sync wins over advance
      for (int k = 0; k < 110; k++) cyc(0, ($urandom % 4) != 0);
      for (int k = 0; k < 4; k++) cyc(0, 1);  // R8 stays idle
    end

    // sync arriving mid-frame restarts at slot 0
    sel_mode = 2'b11; rx_en = rnd128(); tx_en = rnd128();
    cyc(1, 0);
    for (int k = 0; k < 20; k++) cyc(0, 1);
    cyc(1, 1);
    for (int k = 0; k < 70; k++) cyc(0, 1);

    // R11: upper vector bits must not reach narrow slots
    r11_phase = 1; sel_mode = 2'b01;
    tx_en = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h0};
    rx_en = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h0};
    cyc(1, 0);
    for (int k = 0; k < 66; k++) cyc(0, 1);
    r11_phase = 0;

    // wide operation
    for (int md = 1; md < 4; md += 2) begin
      sel_mode = 2'(md); wide_sel = 1;
      rx_en = rnd128(); tx_en = rnd128();
      cyc(1, 0);
      for (int k = 0; k < 132; k++) cyc(0, 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule